// File: doc/BRIEF.md
# Conditional Execution Check Unit

This block decides, one instruction at a time, whether an instruction may execute given the four arithmetic status flags. It accepts the raw instruction word, the status word, the current program counter and a flag saying whether the processor is in its 16-bit (narrow) or 32-bit (wide) instruction state. One clock later it reports a pass bit and the address of the following instruction, which is the address to use if the instruction is skipped.

In wide state every instruction carries a 4-bit condition code in its top nibble. In narrow state only conditional branches are tested. These are the halfwords whose bits 15:12 equal 0xD, and they carry the code in bits 11:8. Every other narrow instruction passes unconditionally. The block performs no execution and never writes the flags.

Top module: `cond_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid, out_pass and out_skip_pc are all zero.
- R2: out_valid is high exactly one cycle after in_valid was high, and that cycle's out_pass and out_skip_pc describe the instruction presented alongside it.
- R3: The flags are read from the status word with N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. Codes 0/1 pass on Z set/clear, 2/3 on C set/clear, 4/5 on N set/clear, and 6/7 on V set/clear.
- R4: Code 8 passes when C=1 and Z=0. Code 9 passes when C=0 or Z=1.
- R5: Code 10 passes when N equals V. Code 11 passes when N differs from V.
- R6: Code 12 passes when Z=0 and N equals V. Code 13 passes when Z=1 or N differs from V.
- R7: Codes 14 and 15 pass whatever the flags.
- R8: In narrow state (in_narrow=1), an instruction with bits 15:12 equal to 0xD is tested using bits 11:8 as its code. Any other narrow instruction passes. Bits 31:16 are ignored in narrow state.
- R9: out_skip_pc equals in_pc plus 4 in wide state and plus 2 in narrow state, wrapping modulo 2^32.
- R10: Status bits 27:0 have no effect on out_pass.
- R11: A cycle with in_valid low leaves out_pass and out_skip_pc unchanged and drives out_valid low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented this cycle |
| in_narrow | input | 1 | 1 selects 16-bit instruction state |
| in_instr | input | 32 | Instruction word; narrow instructions use bits 15:0 |
| in_status | input | 32 | Status word holding N, Z, C, V in bits 31:28 |
| in_pc | input | 32 | Address of the instruction |
| out_valid | output | 1 | Result registered for the previous valid input |
| out_pass | output | 1 | Instruction may execute |
| out_skip_pc | output | 32 | Address of the following instruction |

## Verification
The assertions assume that in_narrow, in_instr, in_status and in_pc are defined on every cycle in which in_valid is high. They also assume that reset lasts at least one clock edge. The bench drives every input from a known value at the falling edge, so no unknown value is ever sampled. It holds reset over several edges before releasing it. The idle-cycle checks deliberately change the data inputs while in_valid is low, which confirms that the outputs hold.

// File: rtl/cond_gate.sv
module cond_gate #(
  parameter int PC_W        = 32,
  parameter int INSTR_W     = 32,
  parameter int WIDE_STEP   = 4,
  parameter int NARROW_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_narrow,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [31:0]       in_status,
  input  logic [PC_W-1:0]   in_pc,
  output logic              out_valid,
  output logic              out_pass,
  output logic [PC_W-1:0]   out_skip_pc
);

  localparam int N_POS = 31;
  localparam int Z_POS = 30;
  localparam int C_POS = 29;
  localparam int V_POS = 28;
  localparam logic [3:0] BRANCH_OP = 4'hD;
  localparam logic [3:0] ALWAYS    = 4'hE;
  localparam logic [PC_W-1:0] STEP_W = PC_W'(WIDE_STEP);
  localparam logic [PC_W-1:0] STEP_N = PC_W'(NARROW_STEP);

  logic       fn, fz, fc, fv;
  logic       narrow_br;
  logic [3:0] code;
  logic       base, pass_c;
  logic [PC_W-1:0] next_pc;

  assign fn = in_status[N_POS];
  assign fz = in_status[Z_POS];
  assign fc = in_status[C_POS];
  assign fv = in_status[V_POS];

  assign narrow_br = (in_instr[15:12] == BRANCH_OP);
  assign code = in_narrow ? (narrow_br ? in_instr[11:8] : ALWAYS)
                          : in_instr[INSTR_W-1 -: 4];

  always_comb begin
    case (code[3:1])
      3'd0:    base = fz;
      3'd1:    base = fc;
      3'd2:    base = fn;
      3'd3:    base = fv;
      3'd4:    base = fc & ~fz;
      3'd5:    base = (fn == fv);
      3'd6:    base = ~fz & (fn == fv);
      default: base = 1'b1;
    endcase
  end

  assign pass_c  = (code[0] && code[3:1] != 3'd7) ? ~base : base;
  assign next_pc = in_pc + (in_narrow ? STEP_N : STEP_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_pass    <= 1'b0;
      out_skip_pc <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pass    <= pass_c;
        out_skip_pc <= next_pc;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_pass) && $stable(out_skip_pc)); // R11
  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_narrow && in_instr[INSTR_W-1 -: 3] == 3'b111 |=> out_pass); // R7
  AST_NARROW_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_narrow && in_instr[15:12] != BRANCH_OP |=> out_pass); // R8
  AST_NV_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_narrow && in_instr[INSTR_W-1 -: 4] == 4'd10 &&
    in_status[N_POS] == in_status[V_POS] |=> out_pass); // R5
  AST_NARROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_narrow |=> out_skip_pc[0] == $past(in_pc[0])); // R9

endmodule

// File: tb/cond_gate_tb.sv
module cond_gate_tb;
  logic clk = 1'b0;
  logic rst_n, in_valid, in_narrow;
  logic [31:0] in_instr, in_status, in_pc;
  logic out_valid, out_pass;
  logic [31:0] out_skip_pc;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cond_gate u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_narrow(in_narrow),
    .in_instr(in_instr), .in_status(in_status), .in_pc(in_pc),
    .out_valid(out_valid), .out_pass(out_pass), .out_skip_pc(out_skip_pc)
  );

  function automatic bit exp_pass(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string code_req(input logic [3:0] c);
    if (c < 8) return "R3";
    if (c < 10) return "R4";
    if (c < 12) return "R5";
    if (c < 14) return "R6";
    return "R7";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input bit nar, input logic [31:0] ins, input logic [31:0] st,
                     input logic [31:0] pc, input bit ep, input string req);
    logic [31:0] epc;
    @(negedge clk);
    in_valid = 1'b1; in_narrow = nar; in_instr = ins; in_status = st; in_pc = pc;
    epc = pc + (nar ? 32'd2 : 32'd4);
    @(negedge clk);
    check(out_valid == 1'b1, "R2", {31'd0, out_valid}, 32'd1);
    check(out_pass == ep, req, {31'd0, out_pass}, {31'd0, ep});
    check(out_skip_pc == epc, "R9", out_skip_pc, epc);
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_narrow = 1'b0;
    in_instr = '0; in_status = '0; in_pc = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_pass == 0 && out_skip_pc == 0, "R1", out_skip_pc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && out_pass == 0 && out_skip_pc == 0, "R1", {31'd0, out_valid}, 32'd0);

    // wide sweep: every code against every flag combination, junk in low status bits (R10)
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] pc;
        pc = (f == 15) ? 32'hFFFF_FFFC : 32'h0000_1000 + 32'(c * 64 + f * 4);
        run(1'b0, {4'(c), 28'(32'h0ABC_DEF1 ^ 32'(f * 99991))},
            {4'(f), 28'(32'h05A5_A5A5 * 32'(c + 1))}, pc,
            exp_pass(4'(c), 4'(f)), (f[0] && c == 3) ? "R10" : code_req(4'(c)));
      end
    end

    // narrow conditional branches: code in 11:8, junk above bit 15 (R8)
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [31:0] pc;
        pc = (f == 7) ? 32'hFFFF_FFFE : 32'h0000_2000 + 32'(c * 32 + f * 2);
        run(1'b1, {16'(32'hF00F ^ 32'(f * 7919)), 4'hD, 4'(c), 8'(f * 13)},
            {4'(f), 28'h0FF_FFFF}, pc, exp_pass(4'(c), 4'(f)), "R8");
      end
    end

    // narrow non-branch: always passes even with a failing code in 11:8 (R8)
    for (int t = 0; t < 16; t++) begin
      if (t == 13) continue;
      for (int f = 0; f < 16; f++) begin
        run(1'b1, {16'hD0D0, 4'(t), 4'(f), 8'h00}, {4'(f), 28'd0},
            32'h0000_3000 + 32'(t * 32 + f * 2), 1'b1, "R8");
      end
    end

    // idle cycle: a failing result must hold while new inputs change (R11)
    run(1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_4000, 1'b0, "R3");
    @(negedge clk);
    in_valid = 1'b0; in_narrow = 1'b1; in_instr = 32'h0000_E000;
    in_status = 32'hF000_0000; in_pc = 32'h0000_9000;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", {31'd0, out_valid}, 32'd0);
    check(out_pass == 1'b0, "R11", {31'd0, out_pass}, 32'd0);
    check(out_skip_pc == 32'h0000_4004, "R11", out_skip_pc, 32'h0000_4004);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule